// File: doc/BRIEF.md
# Protection Group Access Checker

This block decides whether one memory access may proceed. It holds two 32-bit protection words, one for the instruction side and one for the data side. Each word is split into sixteen 2-bit group codes. An access brings a 4-bit group number taken from its matched translation entry, two page protection bits, the privilege of the requester (user or supervisor), whether it reads or writes, and which side it belongs to. A mode input chooses how a group code is read. In domain mode the code grants client or manager rights, or denies access. In key mode the code overrides or swaps the requester's privilege before the page protection bits are checked.

Accesses enter on a valid/ready port and each one yields a single registered verdict on a valid/ready result port. The input is ready whenever the result stage is empty or is being emptied in the same cycle. While the result is stalled, a new access is not taken and the held verdict does not change. The protection words are written and read through a plain register port.

Top module: `prot_group_checker`

## Requirements
- R1: After reset both protection words read 0, `res_valid` is low and `acc_ready` is high.
- R2: `reg_wr` writes `reg_wdata` into the word chosen by `reg_sel` (0 instruction, 1 data). The write is visible on `reg_rdata` (which shows the word chosen by `reg_sel`) in the next cycle. Group g uses bits [31-2g:30-2g], so group 0 is the most significant pair. `acc_side` chooses the word that an access uses.
- R3: With `key_mode`=0, group code 00 denies every access.
- R4: With `key_mode`=0, the reserved code 10 denies every access and raises the fault.
- R5: With `key_mode`=0, code 11 permits every access whatever the page protection bits are.
- R6: With `key_mode`=0, code 01 applies the page protection bits with the requester's real privilege (`acc_user`=1 means user).
- R7: The page protection encoding of `acc_pp` is: 00 supervisor read/write and no user access; 01 supervisor read/write and user read; 10 read/write for all; 11 read for all and no writes.
- R8: With `key_mode`=1, code 00 checks every access as supervisor and code 11 checks every access as user.
- R9: With `key_mode`=1, code 01 uses the real privilege and code 10 uses the opposite privilege.
- R10: `acc_ready` = !`res_valid` | `res_ready`. An access taken on a clock edge shows its verdict with `res_valid` high after that edge. While `res_valid` is high and `res_ready` is low, the verdict stays fixed.
- R11: When `res_valid` is high, `res_fault` is the inverse of `res_permit`. When `res_valid` is low, both are low.
- R12: An access taken in the same cycle as a register write is judged against the old register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_mode | input | 1 | 0 domain mode, 1 key mode |
| reg_wr | input | 1 | Protection word write strobe |
| reg_sel | input | 1 | Word select for write and read (0 instruction, 1 data) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Contents of the selected word |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Access request accepted when high with acc_valid |
| acc_side | input | 1 | Side of the access (0 instruction, 1 data) |
| acc_group | input | 4 | Group number from the translation entry |
| acc_user | input | 1 | 1 user, 0 supervisor |
| acc_write | input | 1 | 1 write, 0 read |
| acc_pp | input | 2 | Page protection bits |
| res_valid | output | 1 | Verdict valid |
| res_ready | input | 1 | Consumer takes the verdict |
| res_permit | output | 1 | Access allowed |
| res_fault | output | 1 | Access refused |

## Verification
A wrong bit in a stored protection word shows up on `reg_rdata` in the cycle after the write. It also shows up one cycle after any access to the affected group, as a flipped `res_permit`/`res_fault` pair. A wrong field offset or side choice shows only when a neighbouring group or the other side holds a different code, so the bench fills those with codes that differ from the tested one. A fault in the result stage shows in the cycle where a stall begins, as a changing verdict or a wrong `acc_ready`.

// File: rtl/prot_pkg.sv
package prot_pkg;
  // group code values, shared by both interpretations
  localparam logic [1:0] GC_00 = 2'b00;
  localparam logic [1:0] GC_01 = 2'b01;
  localparam logic [1:0] GC_10 = 2'b10;
  localparam logic [1:0] GC_11 = 2'b11;

  typedef enum logic [1:0] {
    PP_SUP_ONLY = 2'b00,
    PP_USR_RD   = 2'b01,
    PP_ALL_RW   = 2'b10,
    PP_ALL_RD   = 2'b11
  } page_prot_e;

  typedef struct packed {
    logic       user;
    logic       write;
    page_prot_e pp;
  } acc_attr_t;
endpackage

// File: rtl/prot_bank.sv
module prot_bank #(
  parameter int NUM_SIDES = 2,
  parameter int DATA_W    = 32,
  localparam int SIDE_W   = (NUM_SIDES > 1) ? $clog2(NUM_SIDES) : 1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [SIDE_W-1:0]                  sel,
  input  logic [DATA_W-1:0]                  wr_data,
  output logic [DATA_W-1:0]                  rd_data,
  output logic [NUM_SIDES-1:0][DATA_W-1:0]   words
);
  generate
    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_word
      always_ff @(posedge clk) begin
        if (!rst_n)
          words[s] <= '0;
        else if (wr_en && sel == SIDE_W'(s))
          words[s] <= wr_data;
      end
    end
  endgenerate

  assign rd_data = words[sel];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (sel != $past(sel) || rd_data == $past(wr_data))); // R2
endmodule

// File: rtl/prot_field_sel.sv
module prot_field_sel #(
  parameter int NUM_SIDES  = 2,
  parameter int NUM_GROUPS = 16,
  parameter int CODE_W     = 2,
  localparam int DATA_W    = NUM_GROUPS * CODE_W,
  localparam int SIDE_W    = (NUM_SIDES > 1) ? $clog2(NUM_SIDES) : 1,
  localparam int GRP_W     = $clog2(NUM_GROUPS)
) (
  input  logic [NUM_SIDES-1:0][DATA_W-1:0] words,
  input  logic [SIDE_W-1:0]                side,
  input  logic [GRP_W-1:0]                 group,
  output logic [CODE_W-1:0]                code
);
  logic [NUM_SIDES-1:0][NUM_GROUPS-1:0][CODE_W-1:0] fields;

  // group 0 sits in the most significant pair of each word
  generate
    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
      for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        assign fields[s][g] = words[s][DATA_W-1-g*CODE_W -: CODE_W];
      end
    end
  endgenerate

  assign code = fields[side][group];
endmodule

// File: rtl/prot_decide.sv
module prot_decide
  import prot_pkg::*;
(
  input  logic      key_mode,
  input  logic [1:0] code,
  input  acc_attr_t attr,
  output logic      permit
);
  logic eff_user;
  logic pp_ok;
  logic use_pages;
  logic fixed_verdict;

  // effective privilege after the group code has acted on it
  always_comb begin
    eff_user = attr.user;
    if (key_mode) begin
      unique case (code)
        GC_00:   eff_user = 1'b0;
        GC_01:   eff_user = attr.user;
        GC_10:   eff_user = ~attr.user;
        default: eff_user = 1'b1;
      endcase
    end
  end

  always_comb begin
    unique case (attr.pp)
      PP_SUP_ONLY: pp_ok = ~eff_user;
      PP_USR_RD:   pp_ok = ~eff_user | ~attr.write;
      PP_ALL_RW:   pp_ok = 1'b1;
      default:     pp_ok = ~attr.write;
    endcase
  end

  // domain mode: deny, client, reserved(deny), manager
  always_comb begin
    use_pages     = 1'b1;
    fixed_verdict = 1'b0;
    if (!key_mode) begin
      unique case (code)
        GC_01:   use_pages = 1'b1;
        GC_11:   begin use_pages = 1'b0; fixed_verdict = 1'b1; end
        default: begin use_pages = 1'b0; fixed_verdict = 1'b0; end
      endcase
    end
  end

  assign permit = use_pages ? pp_ok : fixed_verdict;
endmodule

// File: rtl/prot_group_checker.sv
module prot_group_checker
  import prot_pkg::*;
#(
  parameter int NUM_GROUPS = 16,
  parameter int CODE_W     = 2,
  parameter int NUM_SIDES  = 2,
  localparam int DATA_W    = NUM_GROUPS * CODE_W,
  localparam int GRP_W     = $clog2(NUM_GROUPS),
  localparam int SIDE_W    = (NUM_SIDES > 1) ? $clog2(NUM_SIDES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_mode,
  input  logic              reg_wr,
  input  logic [SIDE_W-1:0] reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [SIDE_W-1:0] acc_side,
  input  logic [GRP_W-1:0]  acc_group,
  input  logic              acc_user,
  input  logic              acc_write,
  input  logic [1:0]        acc_pp,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_permit,
  output logic              res_fault
);
  logic [NUM_SIDES-1:0][DATA_W-1:0] words;
  logic [CODE_W-1:0]                grp_code;
  logic                             dec_permit;
  logic                             fire;
  logic                             valid_q;
  logic                             permit_q;
  acc_attr_t                        attr;

  assign attr.user  = acc_user;
  assign attr.write = acc_write;
  assign attr.pp    = page_prot_e'(acc_pp);

  prot_bank #(.NUM_SIDES(NUM_SIDES), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .sel(reg_sel),
    .wr_data(reg_wdata), .rd_data(reg_rdata), .words(words)
  );

  prot_field_sel #(.NUM_SIDES(NUM_SIDES), .NUM_GROUPS(NUM_GROUPS), .CODE_W(CODE_W)) u_sel (
    .words(words), .side(acc_side), .group(acc_group), .code(grp_code)
  );

  prot_decide u_dec (
    .key_mode(key_mode), .code(grp_code), .attr(attr), .permit(dec_permit)
  );

  assign acc_ready = ~valid_q | res_ready;
  assign fire      = acc_valid & acc_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      permit_q <= 1'b0;
    end else if (acc_ready) begin
      valid_q  <= acc_valid;
      permit_q <= acc_valid & dec_permit;
    end
  end

  assign res_valid  = valid_q;
  assign res_permit = permit_q;
  assign res_fault  = valid_q & ~permit_q;

  AST_DOM_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !key_mode && grp_code == GC_00 |=> res_fault); // R3
  AST_DOM_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !key_mode && grp_code == GC_10 |=> res_fault && !res_permit); // R4
  AST_DOM_MGR: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !key_mode && grp_code == GC_11 |=> res_permit); // R5
  AST_KEY_SUP: assert property (@(posedge clk) disable iff (!rst_n)
    fire && key_mode && grp_code == GC_00 && acc_pp == 2'b00 |=> res_permit); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_permit)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !res_permit && !res_fault); // R11
endmodule

// File: tb/sim_prot_group_checker.sv
module sim_prot_group_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        key_mode = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic        acc_side = 1'b0;
  logic [3:0]  acc_group = '0;
  logic        acc_user = 1'b0;
  logic        acc_write = 1'b0;
  logic [1:0]  acc_pp = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_permit;
  logic        res_fault;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  prot_group_checker u0 (.*);

  // reference state
  logic [31:0] m_word [2];
  bit m_valid, m_permit;

  function automatic bit ref_ok(bit km, bit [1:0] c, bit u, bit w, bit [1:0] pp);
    bit eu;
    bit [3:0] rights; // {sup_rd, sup_wr, usr_rd, usr_wr}
    if (!km) begin
      if (c == 2'd0 || c == 2'd2) return 1'b0;
      if (c == 2'd3) return 1'b1;
      eu = u;
    end else begin
      case (c)
        2'd0: eu = 1'b0;
        2'd1: eu = u;
        2'd2: eu = !u;
        default: eu = 1'b1;
      endcase
    end
    case (pp)
      2'd0: rights = 4'b1100;
      2'd1: rights = 4'b1110;
      2'd2: rights = 4'b1111;
      default: rights = 4'b1010;
    endcase
    return rights[3 - (int'(eu) * 2 + int'(w))];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_word[0] = '0; m_word[1] = '0; m_valid = 0; m_permit = 0;
    end else begin
      if (!m_valid || res_ready) begin
        m_valid  = acc_valid;
        m_permit = acc_valid &&
          ref_ok(key_mode, m_word[acc_side][31 - 2*acc_group -: 2], acc_user, acc_write, acc_pp);
      end
      if (reg_wr) m_word[reg_sel] = reg_wdata;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, "res_valid", 32'(res_valid), 32'(m_valid));
      chk(cur_req, "res_permit", 32'(res_permit), 32'(m_permit));
      chk("R11", "res_fault", 32'(res_fault), 32'(m_valid && !m_permit));
      chk("R10", "acc_ready", 32'(acc_ready), 32'(!m_valid || res_ready));
      chk("R2", "reg_rdata", reg_rdata, m_word[reg_sel]);
    end
  end

  task automatic step();
    @(posedge clk); #5;
  endtask

  task automatic write_word(bit side, logic [31:0] data);
    reg_sel = side; reg_wdata = data; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  function automatic logic [31:0] fill(bit [1:0] bg, int grp, bit [1:0] c);
    logic [31:0] v = {16{bg}};
    v[31 - 2*grp -: 2] = c;
    return v;
  endfunction

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    #1;
    cur_req = "R1";
    chk("R1", "reset res_valid", 32'(res_valid), 32'd0);
    chk("R1", "reset acc_ready", 32'(acc_ready), 32'd1);
    chk("R1", "reset word0", reg_rdata, 32'd0);
    step();
    cur_req = "R2";
    write_word(0, 32'hA5C3_0F96);
    write_word(1, 32'h1234_FEDC);
    reg_sel = 0; step();
    reg_sel = 1; step();

    // exhaustive sweep over side, mode, code, privilege, direction, page bits
    for (int idx = 0; idx < 256; idx++) begin
      bit sd, km, u, w;
      bit [1:0] c, pp;
      int grp;
      {sd, km, c, u, w, pp} = 8'(idx);
      grp = idx % 16;
      write_word(sd, fill(~c, grp, c));
      write_word(!sd, {16{c ^ 2'b01}});
      if (!km) cur_req = (c == 0) ? "R3" : (c == 2) ? "R4" : (c == 3) ? "R5" : (pp == 3) ? "R7" : "R6";
      else     cur_req = (c == 0 || c == 3) ? "R8" : "R9";
      key_mode = km; acc_side = sd; acc_group = 4'(grp);
      acc_user = u; acc_write = w; acc_pp = pp; acc_valid = 1'b1;
      step();
      acc_valid = 1'b0;
      step();
    end

    // back-pressure: verdict must hold while stalled
    cur_req = "R10";
    key_mode = 0;
    write_word(0, 32'hFFFF_FFFF);
    write_word(1, 32'h0000_0000);
    res_ready = 1'b0;
    acc_side = 0; acc_group = 4'd5; acc_valid = 1'b1;
    step();
    acc_side = 1;
    repeat (3) step();
    res_ready = 1'b1;
    step();
    acc_valid = 1'b0;
    step(); step();

    // access in the same cycle as a write uses the old word
    cur_req = "R12";
    acc_side = 0; acc_group = 4'd0; acc_pp = 2'd0; acc_user = 1;
    reg_sel = 0; reg_wdata = 32'h0000_0000; reg_wr = 1'b1; acc_valid = 1'b1;
    step();
    reg_wr = 1'b0; acc_valid = 1'b0;
    step(); step();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule